// File: doc/BRIEF.md
# Double-Buffered Data Latch Controller

This block holds a converter code in two register stages. The staging register captures the data bus while a write is in progress. The output register then drives the converter. Three active-low controls govern it: a select, a write strobe and a load. The block runs on a system clock, and it samples the level-sensitive controls at every rising edge.

The staging register follows the bus for as long as select and write are both low. The output register copies the staging register while load is low. That copy is held off while a write is in progress, so a write that overlaps load can never pass a half-formed code to the converter. When the write ends with load still low, the final written code moves across on the next cycle. A one-cycle update flag marks every cycle in which the output code changes.

Top module: `dbl_latch_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, both `staged_code` and `dac_code` become all zeros and `dac_update` becomes 0 after that edge.
- R2: At an edge where `sel_n` or `wr_n` is high, `staged_code` keeps its value.
- R3: At an edge where `sel_n` and `wr_n` are both low, `staged_code` takes the value of `data_in` sampled at that edge.
- R4: At an edge where `ld_n` is low and no write is in progress, `dac_code` takes the value `staged_code` had before that edge.
- R5: At an edge where `ld_n` is low and a write is in progress (`sel_n` and `wr_n` both low), `dac_code` keeps its value.
- R6: When a write ends while `ld_n` stays low, `dac_code` holds the last code written, one edge after the write strobe rises.
- R7: At an edge where `ld_n` is high, `dac_code` keeps its value.
- R8: `dac_update` is 1 for exactly those cycles in which `dac_code` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n | input | 1 | Select, active low |
| wr_n | input | 1 | Write strobe, active low |
| ld_n | input | 1 | Load into output stage, active low |
| data_in | input | CODE_W | Input data bus |
| staged_code | output | CODE_W | Staging register contents |
| dac_code | output | CODE_W | Output register driving the converter |
| dac_update | output | 1 | High for one cycle when `dac_code` changed |

## Verification
A write and a load can fall in the same cycle. In that case the load must be inhibited, and it must commit one cycle after the write is released. The bench holds `ld_n` low across bursts of write cycles with changing data, then raises `wr_n` while load stays low. It also draws random control patterns in which load and write overlap often. A cycle model judges each overlap cycle: it gives the expected output code and update flag, and it tags every mismatch as an inhibit (R5) or a commit (R6) error.

// File: rtl/dbl_latch_pkg.sv
package dbl_latch_pkg;
  typedef enum logic [1:0] {
    XFER_HOLD    = 2'd0,
    XFER_PASS    = 2'd1,
    XFER_INHIBIT = 2'd2
  } xfer_e;

  function automatic xfer_e decode_xfer(input logic ld_n, input logic wr_active);
    if (ld_n)           return XFER_HOLD;
    else if (wr_active) return XFER_INHIBIT;
    else                return XFER_PASS;
  endfunction
endpackage

// File: rtl/dbl_latch_stage_in.sv
module dbl_latch_stage_in #(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [CODE_W-1:0] bus,
  output logic [CODE_W-1:0] held
);
  always_ff @(posedge clk) begin
    if (rst)          held <= '0;
    else if (capture) held <= bus;
  end
endmodule

// File: rtl/dbl_latch_stage_out.sv
module dbl_latch_stage_out #(
  parameter int CODE_W = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dbl_latch_pkg::xfer_e mode,
  input  logic [CODE_W-1:0]    src,
  output logic [CODE_W-1:0]    held,
  output logic                 changed
);
  import dbl_latch_pkg::*;

  logic [CODE_W-1:0] nxt;

  always_comb begin
    nxt = held;
    if (mode == XFER_PASS) nxt = src;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= '0;
      changed <= 1'b0;
    end else begin
      held    <= nxt;
      changed <= (nxt != held);
    end
  end
endmodule

// File: rtl/dbl_latch_ctrl.sv
module dbl_latch_ctrl #(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              ld_n,
  input  logic [CODE_W-1:0] data_in,
  output logic [CODE_W-1:0] staged_code,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_update
);
  import dbl_latch_pkg::*;

  logic  wr_active;
  xfer_e mode;

  assign wr_active = ~sel_n & ~wr_n;
  assign mode      = decode_xfer(ld_n, wr_active);

  dbl_latch_stage_in #(.CODE_W(CODE_W)) u_in (
    .clk     (clk),
    .rst     (rst),
    .capture (wr_active),
    .bus     (data_in),
    .held    (staged_code)
  );

  dbl_latch_stage_out #(.CODE_W(CODE_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .src     (staged_code),
    .held    (dac_code),
    .changed (dac_update)
  );
endmodule

// File: rtl/dbl_latch_ctrl_checker.sv
module dbl_latch_ctrl_checker #(
  parameter int CODE_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_n,
  input logic              wr_n,
  input logic              ld_n,
  input logic [CODE_W-1:0] data_in,
  input logic [CODE_W-1:0] staged_code,
  input logic [CODE_W-1:0] dac_code,
  input logic              dac_update
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (staged_code == '0 && dac_code == '0 && !dac_update));

  assert_stage_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (sel_n || wr_n) |=> $stable(staged_code));

  assert_stage_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (!sel_n && !wr_n) |=> (staged_code == $past(data_in)));

  assert_load_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (!ld_n && (sel_n || wr_n)) |=> (dac_code == $past(staged_code)));

  assert_load_inhibit_R5: assert property (@(posedge clk) disable iff (rst)
    (!ld_n && !sel_n && !wr_n) |=> $stable(dac_code));

  assert_write_commit_R6: assert property (@(posedge clk) disable iff (rst)
    (!ld_n && !$past(ld_n) && !sel_n && $rose(wr_n) && !$past(sel_n))
      |=> (dac_code == $past(staged_code)));

  assert_no_load_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ld_n |=> $stable(dac_code));

  assert_update_flag_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dac_update == (dac_code != $past(dac_code))));
endmodule

bind dbl_latch_ctrl dbl_latch_ctrl_checker #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/dbl_latch_ctrl_test.sv
module dbl_latch_ctrl_test;
  localparam int W = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] staged_code, dac_code;
  logic dac_update;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state
  logic [W-1:0] m_in = '0, m_out = '0;
  logic m_upd = 1'b0;
  string tag_in = "R1", tag_out = "R1";
  logic prev_wa = 1'b0;

  always #4 clk = ~clk;

  dbl_latch_ctrl #(.CODE_W(W)) uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .ld_n(ld_n),
    .data_in(data_in), .staged_code(staged_code), .dac_code(dac_code),
    .dac_update(dac_update)
  );

  function automatic logic [W-1:0] next_out(input logic ld, input logic wa,
                                            input logic [W-1:0] cur_in,
                                            input logic [W-1:0] cur_out);
    return (!ld && !wa) ? cur_in : cur_out;
  endfunction

  always @(posedge clk) begin
    logic wa;
    logic [W-1:0] n_in, n_out;
    wa = !sel_n && !wr_n;
    if (rst) begin
      n_in = '0; n_out = '0; m_upd = 1'b0;
      tag_in = "R1"; tag_out = "R1";
    end else begin
      n_in  = wa ? data_in : m_in;
      n_out = next_out(ld_n, wa, m_in, m_out);
      m_upd = (n_out != m_out);
      tag_in  = wa ? "R3" : "R2";
      tag_out = ld_n ? "R7" : (wa ? "R5" : (prev_wa ? "R6" : "R4"));
    end
    prev_wa = wa && !rst;
    m_in = n_in;
    m_out = n_out;
  end

  task automatic check_outputs();
    checks++;
    if (staged_code !== m_in) begin
      failures++;
      $display("FAIL %s staged_code actual=%h expected=%h", tag_in, staged_code, m_in);
    end
    checks++;
    if (dac_code !== m_out) begin
      failures++;
      $display("FAIL %s dac_code actual=%h expected=%h", tag_out, dac_code, m_out);
    end
    checks++;
    if (dac_update !== m_upd) begin
      failures++;
      $display("FAIL R8 dac_update actual=%b expected=%b", dac_update, m_upd);
    end
  endtask

  task automatic step(input logic s, input logic w, input logic l, input logic [W-1:0] d);
    sel_n = s; wr_n = w; ld_n = l; data_in = d;
    @(negedge clk);
    check_outputs();
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    @(negedge clk);
    check_outputs();                  // R1 reset state
    rst = 1'b0;
    // directed: write then load (R3, R4, R8)
    step(1'b0, 1'b0, 1'b1, 14'h1ABC);
    step(1'b1, 1'b1, 1'b1, 14'h0000); // R2 hold
    step(1'b1, 1'b1, 1'b0, 14'h0000); // R4 pass
    step(1'b1, 1'b1, 1'b0, 14'h0000); // R8 no change
    // directed: write overlapping load (R5), then commit (R6)
    step(1'b0, 1'b0, 1'b0, 14'h2345);
    step(1'b0, 1'b0, 1'b0, 14'h3FFF);
    step(1'b0, 1'b0, 1'b0, 14'h0001);
    step(1'b0, 1'b1, 1'b0, 14'h3FFF); // write ends, load low
    step(1'b0, 1'b1, 1'b0, 14'h3FFF); // R6 committed
    // select high blocks write (R2) and load high holds output (R7)
    step(1'b1, 1'b0, 1'b1, 14'h0F0F);
    step(1'b0, 1'b0, 1'b1, 14'h3FFF);
    step(1'b1, 1'b1, 1'b1, 14'h0000);
    step(1'b1, 1'b1, 1'b0, 14'h0000);
    // reset mid-run (R1)
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b0, 14'h0000);
    rst = 1'b0;
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic s, w, l;
      s = ($urandom_range(0, 3) == 0);
      w = ($urandom_range(0, 2) == 0);
      l = ($urandom_range(0, 1) == 0);
      step(s, w, l, W'($urandom));
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule